// File: doc/BRIEF.md
# Dual UART Baud Tick Prescaler

The block turns one of several parent clock sources into baud-rate tick enables for two UARTs. All logic runs on a single system clock. Each parent source is presented as a one-cycle enable pulse on that clock: one line for the crystal and four lines for alternate sources. A shared 32-bit control word chooses the source for both UARTs. The same word also holds a cascade of two pre-dividers, used only on the alternate path, a per-UART clock gate and the first UART's baud divisor. A second 32-bit register holds the baud divisor of the second UART.

Each UART counts pre-divided source pulses up to its own 10-bit divisor. On the final count it emits one single-cycle tick. Reconfiguration never cuts a period short. A new divisor takes effect only after the current period ends. A new source or pre-divide setting takes effect only after the cascade finishes its current cycle. Gating a UART clears its counter and holds its tick low. Gating both UARTs also clears the shared pre-divider and applies its configuration at once.

Top module: `uart_clk_prescaler`

## Requirements
- R1: After reset, both read-back words are zero and both tick outputs are low.
- R2: With control bit 19 clear, the crystal enable drives both UARTs directly, and the pre-divider fields (bits 17:15 and 14:12) and the source index (bits 11:10) have no effect on tick timing.
- R3: With control bit 19 set, the source is alternate enable line number `ctrl[11:10]`, and pulses on the other alternate lines and on the crystal line are not counted.
- R4: On the alternate path, the source is divided by the product of the two 3-bit pre-divider fields, bits 17:15 and then bits 14:12, and this divided rate is shared by both UARTs.
- R5: UART1 (tick_o[0]) divides by control bits 9:0, and UART2 (tick_o[1]) divides by bits 9:0 of the second divisor register, independently of each other.
- R6: A pre-divider value of 0 acts as 1 and a value of 7 acts as 6. A baud divisor of 0 acts as 1.
- R7: Control bit 20 set gates UART1 and bit 21 set gates UART2. A gated UART's tick stays low and its count restarts from zero when the gate is cleared. With both gated, the pre-divider is also cleared.
- R8: A rewritten divisor, source or pre-divider takes effect only at the next terminal count of the affected counter, so the period in progress always completes at its old length.
- R9: A tick is a single-cycle pulse, asserted in the cycle after the source pulse that completes the count.
- R10: Reading back returns the control word's bits 21:0 and the divisor register's bits 9:0, and all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the shared control word |
| ctrl_wdata_i | input | 32 | Control word write data |
| div2_we_i | input | 1 | Write strobe for the UART2 divisor register |
| div2_wdata_i | input | 32 | UART2 divisor write data |
| ctrl_o | output | 32 | Control word read-back |
| div2_o | output | 32 | UART2 divisor read-back |
| xtal_en_i | input | 1 | Crystal source enable pulse |
| alt_en_i | input | 4 | Alternate source enable pulses, one per index |
| tick_o | output | 2 | Baud tick, bit 0 for UART1 and bit 1 for UART2 |

## Verification
A continuous crystal stream with different divisors on the two UARTs separates per-UART division from shared division, while junk in the pre-divider fields shows that those fields do not reach the crystal path. A half-rate crystal stream with zero divisors tests the clamp to 1 and shows that ticks follow source pulses rather than clock cycles. Alternate-source runs drive the selected line steadily and toggle the other lines, so a wrong index or a leaking line shifts the tick positions; the same runs use pre-divider values including 0 and 7 to test the product and both clamps. Rewrites in mid-period, of the divisor and of the source, together with a gated UART, show whether a short tick, a wrong restart or a tick leaking past the gate occurs.

// File: rtl/uart_clk_pkg.sv
package uart_clk_pkg;
  localparam int unsigned BAUD_W   = 10;
  localparam int unsigned PRE_W    = 3;
  localparam int unsigned IDX_W    = 2;
  localparam int unsigned NUM_UART = 2;
  localparam int unsigned PRE_MAX  = 6;
  localparam int unsigned CTL_W    = 22;
  // control word layout
  localparam int unsigned BAUD_LSB = 0;
  localparam int unsigned IDX_LSB  = 10;
  localparam int unsigned PRE2_LSB = 12;
  localparam int unsigned PRE1_LSB = 15;
  localparam int unsigned ALT_BIT  = 19;
  localparam int unsigned GATE_LSB = 20;

  typedef struct packed {
    logic             alt;
    logic [IDX_W-1:0] idx;
    logic [PRE_W-1:0] d1;
    logic [PRE_W-1:0] d2;
  } src_cfg_t;

  function automatic logic [PRE_W-1:0] clamp_pre(input logic [PRE_W-1:0] v);
    if (v == '0) return PRE_W'(1);
    if (v > PRE_W'(PRE_MAX)) return PRE_W'(PRE_MAX);
    return v;
  endfunction

  function automatic logic [BAUD_W-1:0] clamp_div(input logic [BAUD_W-1:0] v);
    if (v == '0) return BAUD_W'(1);
    return v;
  endfunction
endpackage

// File: rtl/uart_clk_regs.sv
module uart_clk_regs
  import uart_clk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            ctrl_we_i,
  input  logic [DATA_W-1:0]               ctrl_wdata_i,
  input  logic                            div2_we_i,
  input  logic [DATA_W-1:0]               div2_wdata_i,
  output logic [DATA_W-1:0]               ctrl_o,
  output logic [DATA_W-1:0]               div2_o,
  output src_cfg_t                        src_cfg_o,
  output logic [NUM_UART-1:0]             gate_o,
  output logic [NUM_UART-1:0][BAUD_W-1:0] div_o
);
  logic [CTL_W-1:0]  ctrl_q;
  logic [BAUD_W-1:0] div2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div2_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i[CTL_W-1:0];
      if (div2_we_i) div2_q <= div2_wdata_i[BAUD_W-1:0];
    end
  end

  assign ctrl_o = DATA_W'(ctrl_q);
  assign div2_o = DATA_W'(div2_q);

  always_comb begin
    src_cfg_o.alt = ctrl_q[ALT_BIT];
    src_cfg_o.idx = ctrl_q[IDX_LSB +: IDX_W];
    src_cfg_o.d1  = clamp_pre(ctrl_q[PRE1_LSB +: PRE_W]);
    src_cfg_o.d2  = clamp_pre(ctrl_q[PRE2_LSB +: PRE_W]);
  end

  assign gate_o   = ctrl_q[GATE_LSB +: NUM_UART];
  assign div_o[0] = clamp_div(ctrl_q[BAUD_LSB +: BAUD_W]);
  assign div_o[1] = clamp_div(div2_q);

  p_ctrl_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_we_i) |-> (ctrl_o == DATA_W'($past(ctrl_wdata_i[CTL_W-1:0]))));
  p_div2_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(div2_we_i) |-> (div2_o == DATA_W'($past(div2_wdata_i[BAUD_W-1:0]))));
endmodule

// File: rtl/uart_clk_divcnt.sv
module uart_clk_divcnt #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] lim_i,
  output logic         term_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == lim_i - W'(1));
  assign term_o = step_i && at_end && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= at_end ? '0 : cnt_q + W'(1);
  end

  // limit only moves while the count is at zero, so the count never passes it
  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i != '0) |-> (cnt_q < lim_i));
endmodule

// File: rtl/uart_clk_prediv.sv
module uart_clk_prediv
  import uart_clk_pkg::*;
#(
  parameter int unsigned NUM_ALT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  src_cfg_t           cfg_i,
  input  logic               xtal_en_i,
  input  logic [NUM_ALT-1:0] alt_en_i,
  output logic               pre_tick_o
);
  localparam int unsigned NUM_STG = 2;
  localparam src_cfg_t CFG_RST = '{alt: 1'b0, idx: '0, d1: PRE_W'(1), d2: PRE_W'(1)};

  src_cfg_t         act_q;
  logic             src;
  logic             stg_clear;
  logic             stg_step [NUM_STG];
  logic             stg_term [NUM_STG];
  logic [PRE_W-1:0] stg_lim  [NUM_STG];

  assign src       = act_q.alt ? alt_en_i[act_q.idx] : xtal_en_i;
  assign stg_clear = hold_i || !act_q.alt;
  assign stg_lim[0] = act_q.d1;
  assign stg_lim[1] = act_q.d2;

  for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
    if (s == 0) begin : g_head
      assign stg_step[s] = src;
    end else begin : g_tail
      assign stg_step[s] = stg_term[s-1];
    end
    uart_clk_divcnt #(.W(PRE_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(stg_clear),
      .step_i (stg_step[s]),
      .lim_i  (stg_lim[s]),
      .term_o (stg_term[s])
    );
  end

  assign pre_tick_o = act_q.alt ? stg_term[NUM_STG-1] : (xtal_en_i && !hold_i);

  // new source settings apply only at a cascade terminal count, or at once while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     act_q <= CFG_RST;
    else if (hold_i || pre_tick_o)   act_q <= cfg_i;
  end

  p_pre_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.d1 >= PRE_W'(1)) && (act_q.d1 <= PRE_W'(PRE_MAX)) &&
    (act_q.d2 >= PRE_W'(1)) && (act_q.d2 <= PRE_W'(PRE_MAX)));
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!hold_i && !pre_tick_o) |-> $stable(act_q));
  p_alt_needs_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.alt && pre_tick_o) |-> alt_en_i[act_q.idx]);
endmodule

// File: rtl/uart_clk_baud.sv
module uart_clk_baud
  import uart_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pre_tick_i,
  input  logic [BAUD_W-1:0] div_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] lim_q;
  logic              term;
  logic              tick_q;

  uart_clk_divcnt #(.W(BAUD_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!en_i),
    .step_i (pre_tick_i),
    .lim_i  (lim_q),
    .term_o (term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= BAUD_W'(1);
      tick_q <= 1'b0;
    end else begin
      if (!en_i || term) lim_q <= div_i;
      tick_q <= term;
    end
  end

  assign tick_o = tick_q;

  p_gate_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
  p_tick_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(pre_tick_i && en_i));
  p_lim_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && !term) |-> $stable(lim_q));
endmodule

// File: rtl/uart_clk_prescaler.sv
module uart_clk_prescaler
  import uart_clk_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_ALT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [DATA_W-1:0]   ctrl_wdata_i,
  input  logic                div2_we_i,
  input  logic [DATA_W-1:0]   div2_wdata_i,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [DATA_W-1:0]   div2_o,
  input  logic                xtal_en_i,
  input  logic [NUM_ALT-1:0]  alt_en_i,
  output logic [NUM_UART-1:0] tick_o
);
  src_cfg_t                        src_cfg;
  logic [NUM_UART-1:0]             gate;
  logic [NUM_UART-1:0][BAUD_W-1:0] div;
  logic                            pre_tick;
  logic                            all_gated;

  uart_clk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .div2_we_i   (div2_we_i),
    .div2_wdata_i(div2_wdata_i),
    .ctrl_o      (ctrl_o),
    .div2_o      (div2_o),
    .src_cfg_o   (src_cfg),
    .gate_o      (gate),
    .div_o       (div)
  );

  assign all_gated = &gate;

  uart_clk_prediv #(.NUM_ALT(NUM_ALT)) u_prediv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (all_gated),
    .cfg_i     (src_cfg),
    .xtal_en_i (xtal_en_i),
    .alt_en_i  (alt_en_i),
    .pre_tick_o(pre_tick)
  );

  for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
    uart_clk_baud u_baud (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (!gate[u]),
      .pre_tick_i(pre_tick),
      .div_i     (div[u]),
      .tick_o    (tick_o[u])
    );
  end
endmodule

// File: tb/sim_uart_clk_prescaler.sv
`timescale 1ns/1ps
module sim_uart_clk_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, div2_we = 1'b0;
  logic [31:0] ctrl_wd = '0, div2_wd = '0;
  logic [31:0] ctrl_rd, div2_rd;
  logic        xtal_en = 1'b0;
  logic [3:0]  alt_en = '0;
  logic [1:0]  tick;

  uart_clk_prescaler u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .div2_we_i(div2_we), .div2_wdata_i(div2_wd),
    .ctrl_o(ctrl_rd), .div2_o(div2_rd),
    .xtal_en_i(xtal_en), .alt_en_i(alt_en), .tick_o(tick)
  );

  always #4 clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    q0[$], q1[$];
  int    tick_cnt [2] = '{0, 0};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // reference state, built from the requirements
  logic [21:0] m_ctrl = '0;
  logic [9:0]  m_div2 = '0;
  bit          m_alt = 1'b0;
  int          m_idx = 0, m_d1 = 1, m_d2 = 1, m_c1 = 0, m_c2 = 0;
  int          m_bl [2] = '{1, 1};
  int          m_bc [2] = '{0, 0};

  function automatic int cp(input logic [2:0] v);
    if (v == 0) return 1;
    if (v == 7) return 6;
    return int'(v);
  endfunction
  function automatic int cd(input logic [9:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // driver: applies one cycle of stimulus and pushes expected tick cycles
  task automatic step(input logic x, input logic [3:0] a, input logic cwe, input logic [31:0] cw,
                      input logic dwe, input logic [31:0] dw);
    bit src, t1, t2, term, hold, en;
    int lim_new;
    @(negedge clk);
    xtal_en = x; alt_en = a; ctrl_we = cwe; ctrl_wd = cw; div2_we = dwe; div2_wd = dw;
    hold = m_ctrl[20] && m_ctrl[21];
    src  = m_alt ? a[m_idx] : x;
    t1   = m_alt && !hold && src && (m_c1 == m_d1 - 1);
    t2   = t1 && (m_c2 == m_d2 - 1);
    term = !hold && (m_alt ? t2 : x);
    if (hold || !m_alt) begin
      m_c1 = 0; m_c2 = 0;
    end else begin
      if (src) m_c1 = t1 ? 0 : m_c1 + 1;
      if (t1)  m_c2 = t2 ? 0 : m_c2 + 1;
    end
    if (hold || term) begin
      m_alt = m_ctrl[19]; m_idx = int'(m_ctrl[11:10]);
      m_d1 = cp(m_ctrl[17:15]); m_d2 = cp(m_ctrl[14:12]);
    end
    for (int u = 0; u < 2; u++) begin
      en = !m_ctrl[20+u];
      lim_new = (u == 0) ? cd(m_ctrl[9:0]) : cd(m_div2);
      if (!en) begin
        m_bc[u] = 0; m_bl[u] = lim_new;
      end else if (term) begin
        if (m_bc[u] == m_bl[u] - 1) begin
          if (u == 0) q0.push_back(cyc + 1); else q1.push_back(cyc + 1);
          m_bc[u] = 0; m_bl[u] = lim_new;
        end else m_bc[u]++;
      end
    end
    if (cwe) m_ctrl = cw[21:0];
    if (dwe) m_div2 = dw[9:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'b0, 1'b0, '0, 1'b0, '0);
  endtask
  task automatic wr_ctrl(input logic [31:0] v);
    step(1'b0, 4'b0, 1'b1, v, 1'b0, '0);
  endtask
  task automatic wr_div2(input logic [31:0] v);
    step(1'b0, 4'b0, 1'b0, '0, 1'b1, v);
  endtask
  task automatic setup(input logic [31:0] c, input logic [31:0] d);
    wr_ctrl(c | 32'h0030_0000);
    wr_div2(d);
    idle(1);
    wr_ctrl(c);
  endtask
  task automatic drain();
    idle(3);
    chk(q0.size() == 0, cur_req, "UART1 ticks still owed", q0.size(), 0);
    chk(q1.size() == 0, cur_req, "UART2 ticks still owed", q1.size(), 0);
    q0.delete(); q1.delete();
  endtask

  // monitor: pops expected tick cycles and compares against the outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int u = 0; u < 2; u++) begin
        bit t, due;
        t   = tick[u];
        due = (u == 0) ? (q0.size() > 0 && q0[0] == cyc) : (q1.size() > 0 && q1[0] == cyc);
        if (t) tick_cnt[u]++;
        if (due) begin
          chk(t == 1'b1, cur_req, $sformatf("UART%0d tick due", u + 1), t, 1);
          if (u == 0) void'(q0.pop_front()); else void'(q1.pop_front());
        end else if (t) begin
          chk(1'b0, cur_req, $sformatf("UART%0d unexpected tick", u + 1), 1, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, s1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrl_rd == 0, "R1", "ctrl read-back", ctrl_rd, 0);
    chk(div2_rd == 0, "R1", "div2 read-back", div2_rd, 0);
    chk(tick == 0, "R1", "tick", tick, 0);
    rst_n = 1'b1;
    idle(2);

    // R10 read-back masking
    cur_req = "R10";
    wr_ctrl(32'hFFFF_FFFF);
    wr_div2(32'hFFFF_FFFF);
    @(negedge clk);
    chk(ctrl_rd == 32'h003F_FFFF, "R10", "ctrl read-back", ctrl_rd, 32'h003F_FFFF);
    chk(div2_rd == 32'h0000_03FF, "R10", "div2 read-back", div2_rd, 32'h3FF);

    // R2, R5: crystal path with junk in pre-divider and index fields
    cur_req = "R2/R5";
    setup((32'd2 << 15) | (32'd3 << 12) | (32'd2 << 10) | 32'd3, 32'd5);
    for (int i = 0; i < 31; i++) step(1'b1, 4'b0, 1'b0, '0, 1'b0, '0);
    drain();

    // R6, R9: zero divisors act as 1, ticks follow a half-rate source
    cur_req = "R6/R9";
    setup(32'd0, 32'd0);
    for (int i = 0; i < 20; i++) step(i[0], 4'b0, 1'b0, '0, 1'b0, '0);
    drain();

    // R3, R4: alternate index 2, pre-divide 2*3, other lines toggling
    cur_req = "R3/R4";
    setup((32'd1 << 19) | (32'd2 << 15) | (32'd3 << 12) | (32'd2 << 10) | 32'd2, 32'd1);
    for (int i = 0; i < 50; i++) begin
      logic o;
      o = i[0];
      step(1'b1, {o, 1'b1, o, ~o}, 1'b0, '0, 1'b0, '0);
    end
    drain();

    // R6, R4: pre-divider fields 0 and 7 clamp to 1 and 6, index 1
    cur_req = "R6/R4";
    setup((32'd1 << 19) | (32'd0 << 15) | (32'd7 << 12) | (32'd1 << 10) | 32'd1, 32'd3);
    for (int i = 0; i < 45; i++) begin
      logic o;
      o = i[0];
      step(o, {1'b1, 1'b1, 1'b1, o}, 1'b0, '0, 1'b0, '0);
    end
    drain();

    // R7: UART2 gated, UART1 runs
    cur_req = "R7";
    setup((32'd1 << 21) | 32'd2, 32'd1);
    s0 = tick_cnt[0]; s1 = tick_cnt[1];
    for (int i = 0; i < 20; i++) step(1'b1, 4'b0, 1'b0, '0, 1'b0, '0);
    drain();
    chk(tick_cnt[1] == s1, "R7", "gated UART2 tick count", tick_cnt[1] - s1, 0);
    chk(tick_cnt[0] - s0 == 10, "R7", "UART1 tick count", tick_cnt[0] - s0, 10);
    // swap gates mid-run; UART1 restarts from zero when ungated again
    wr_ctrl((32'd1 << 20) | 32'd2);
    for (int i = 0; i < 5; i++) step(1'b1, 4'b0, 1'b0, '0, 1'b0, '0);
    wr_ctrl(32'd3);
    for (int i = 0; i < 13; i++) step(1'b1, 4'b0, 1'b0, '0, 1'b0, '0);
    drain();

    // R8: divisor rewritten mid-period, then source switched mid-period
    cur_req = "R8";
    setup(32'd4, 32'd3);
    for (int i = 0; i < 6; i++) step(1'b1, 4'b0, 1'b0, '0, 1'b0, '0);
    wr_ctrl(32'd2);
    for (int i = 0; i < 13; i++) step(1'b1, 4'b0, 1'b0, '0, 1'b0, '0);
    wr_ctrl((32'd1 << 19) | (32'd1 << 15) | (32'd2 << 12) | 32'd2);
    for (int i = 0; i < 30; i++) step(1'b1, {3'b000, i[0]}, 1'b0, '0, 1'b0, '0);
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule